// File: doc/BRIEF.md
# Ready-Latency Packet Stream Transmitter

This block sends one pre-formatted transaction-layer packet at a time over a 128-bit valid/ready streaming link. The link marks the first and last beat of each packet with start and end flags. Its sink works with a fixed ready latency: when the sink raises ready in a cycle, the source may present a beat only a fixed number of cycles later. The upstream logic hands over a complete request in one cycle. A request is a header of three or four dwords, a payload length in dwords, and the payload words. The block copies the request into an internal packet buffer. It works out how many beats the packet needs, then streams those beats out, one in every cycle the delayed ready allows.

Message packets are sent like any packet with a four-dword header. The number of beats must match the header's length information exactly, because a sink that receives too few or too many beats stops accepting traffic. For this reason the beat count is derived from the same header size and length that fill the buffer. After reset the block refuses requests for two clock cycles, because the sink may show ready while it is still resetting.

Top module: `tlpStreamTx`

## Requirements
- R1: While rst_n is low, txValid, txSop, txEop, done and reqReady are all 0 and txData is all zeros.
- R2: After rst_n goes high, reqReady stays low until two rising clock edges have passed with reset released. It is first high in the cycle after the second such edge, so no packet starts within two cycles of reset release.
- R3: A request is taken only in a cycle where reqValid and reqReady are both high. reqReady is low from the cycle after acceptance through the cycle of the packet's end beat, and high again in the following cycle. Requests presented while reqReady is low have no effect, and no beat is ever sent without an accepted request.
- R4: txValid is high in cycle n only if txReady was high in cycle n - READY_LAT, where READY_LAT is 1 or 2 with a default of 2. While an accepted packet still has beats left, every cycle that meets this condition carries a beat.
- R5: A packet is sent as exactly ceil((H + L) / 4) beats. H is 4 when reqHdr4 = 1 and 3 when reqHdr4 = 0. L is reqLen, with 0 <= L <= MAX_PAY.
- R6: The packet's dwords are numbered k = 0, 1, 2 and so on. Header dword j is reqHdr[32j+31:32j]. Payload dword m is reqPayload[32m+31:32m], placed directly after the header. Dword k travels in beat k/4 on bits [32(k mod 4)+31 : 32(k mod 4)]. Dword positions past the last payload dword in the final beat are zero.
- R7: txSop is high only on a packet's first beat and txEop only on its last beat, both only together with txValid. A one-beat packet raises both flags in the same cycle.
- R8: done is high for exactly the cycles in which the end beat of a packet is sent.
- R9: txData is all zeros in every cycle where txValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Upstream request present |
| reqHdr4 | input | 1 | 1: four-dword header, 0: three-dword header |
| reqHdr | input | 128 | Header dwords, dword j at bits 32j+31:32j |
| reqLen | input | LEN_W (4) | Payload length in dwords |
| reqPayload | input | 32*MAX_PAY (384) | Payload dwords, dword m at bits 32m+31:32m |
| txReady | input | 1 | Sink ready |
| reqReady | output | 1 | Block idle and able to take a request |
| txValid | output | 1 | Beat present on txData |
| txSop | output | 1 | First beat of a packet |
| txEop | output | 1 | Last beat of a packet |
| txData | output | DATA_W (128) | Beat data |
| done | output | 1 | Packet end beat sent this cycle |

## Verification
Every output comes from registers that are one clock edge away from the inputs. A request accepted at one edge can therefore produce its first beat as soon as the cycle right after that edge. A ready value first appears on txValid READY_LAT cycles after the cycle in which it was driven, and reqReady returns one cycle after the end beat. The bench drives inputs and samples outputs on the falling edge. It keeps a shift record of the ready values it drove and compares each cycle against the entry READY_LAT places back. It checks every beat against a packet image it built from the request. The reset hold-off is checked at the first and second falling edges after release.

// File: rtl/tlpTxPkg.sv
package tlpTxPkg;
  localparam int DW_W       = 32;
  localparam int BEAT_IDX_W = 4;   // up to 16 beats per packet

  // strobes from control to datapath
  typedef struct packed {
    logic                  load;     // capture a new request
    logic                  fire;     // a beat leaves this cycle
    logic [BEAT_IDX_W-1:0] beatSel;  // which buffered beat to present
  } txStrobe_t;
endpackage

// File: rtl/tlpTxCtrl.sv
module tlpTxCtrl
  import tlpTxPkg::*;
#(
  parameter int READY_LAT = 2,
  parameter int HOLD_CYC  = 2,
  parameter int MAX_PAY   = 12,
  parameter int DATA_W    = 128,
  localparam int LEN_W    = $clog2(MAX_PAY + 1),
  localparam int DPB      = DATA_W / DW_W,
  localparam int TOT_W    = $clog2(MAX_PAY + 4 + DPB) + 1,
  localparam int HOLD_W   = $clog2(HOLD_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqHdr4,
  input  logic [LEN_W-1:0] reqLen,
  input  logic             txReady,
  output logic             reqReady,
  output logic             txValid,
  output logic             txSop,
  output logic             txEop,
  output logic             done,
  output txStrobe_t        strb
);
  logic [HOLD_W-1:0]     holdCnt;
  logic                  holdDone;
  logic [READY_LAT-1:0]  rdyHist;
  logic                  rdyDel;
  logic                  active;
  logic [BEAT_IDX_W-1:0] beatIdx, lastBeat, lastNew;
  logic [TOT_W-1:0]      hdrDw, totDw, beatsNeed;
  logic                  fire, load;

  // reset hold-off counter
  assign holdDone = (holdCnt == HOLD_W'(HOLD_CYC));
  always_ff @(posedge clk) begin
    if (!rst_n)        holdCnt <= '0;
    else if (!holdDone) holdCnt <= holdCnt + HOLD_W'(1);
  end

  // record of past ready values; the oldest entry gates the beat
  generate
    if (READY_LAT == 1) begin : gLat1
      always_ff @(posedge clk) begin
        if (!rst_n) rdyHist <= '0;
        else        rdyHist <= txReady;
      end
    end else begin : gLatN
      always_ff @(posedge clk) begin
        if (!rst_n) rdyHist <= '0;
        else        rdyHist <= {rdyHist[READY_LAT-2:0], txReady};
      end
    end
  endgenerate
  assign rdyDel = rdyHist[READY_LAT-1];

  // beat count of the incoming request
  always_comb begin
    hdrDw     = reqHdr4 ? TOT_W'(4) : TOT_W'(3);
    totDw     = hdrDw + TOT_W'(reqLen);
    beatsNeed = (totDw + TOT_W'(DPB - 1)) / TOT_W'(DPB);
    lastNew   = BEAT_IDX_W'(beatsNeed - TOT_W'(1));
  end

  assign reqReady = !active && holdDone;
  assign load     = reqValid && reqReady;
  assign fire     = active && rdyDel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      beatIdx  <= '0;
      lastBeat <= '0;
    end else if (load) begin
      active   <= 1'b1;
      beatIdx  <= '0;
      lastBeat <= lastNew;
    end else if (fire) begin
      if (beatIdx == lastBeat) active  <= 1'b0;
      else                     beatIdx <= beatIdx + BEAT_IDX_W'(1);
    end
  end

  assign txValid = fire;
  assign txSop   = fire && (beatIdx == '0);
  assign txEop   = fire && (beatIdx == lastBeat);
  assign done    = txEop;

  assign strb.load    = load;
  assign strb.fire    = fire;
  assign strb.beatSel = beatIdx;
endmodule

// File: rtl/tlpTxData.sv
module tlpTxData
  import tlpTxPkg::*;
#(
  parameter int DATA_W    = 128,
  parameter int MAX_PAY   = 12,
  localparam int LEN_W    = $clog2(MAX_PAY + 1),
  localparam int DPB      = DATA_W / DW_W,
  localparam int MAX_BEATS = (4 + MAX_PAY + DPB - 1) / DPB,
  localparam int NDW      = MAX_BEATS * DPB,
  localparam int PIDX_W   = (MAX_PAY > 1) ? $clog2(MAX_PAY) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  txStrobe_t               strb,
  input  logic                    reqHdr4,
  input  logic [127:0]            reqHdr,
  input  logic [LEN_W-1:0]        reqLen,
  input  logic [MAX_PAY*DW_W-1:0] reqPayload,
  output logic [DATA_W-1:0]       txData
);
  logic [DW_W-1:0]   hdrW    [4];
  logic [DW_W-1:0]   payW    [MAX_PAY];
  logic [DW_W-1:0]   nxtDw   [NDW];
  logic [DATA_W-1:0] nxtBeat [MAX_BEATS];
  logic [DATA_W-1:0] pktBeat [MAX_BEATS];
  int                pIdx;

  genvar g, b, j;
  generate
    for (g = 0; g < 4; g++) begin : gHdr
      assign hdrW[g] = reqHdr[DW_W*g +: DW_W];
    end
    for (g = 0; g < MAX_PAY; g++) begin : gPay
      assign payW[g] = reqPayload[DW_W*g +: DW_W];
    end
    for (b = 0; b < MAX_BEATS; b++) begin : gBeat
      for (j = 0; j < DPB; j++) begin : gLane
        assign nxtBeat[b][DW_W*j +: DW_W] = nxtDw[b*DPB + j];
      end
    end
  endgenerate

  // packet image: header, then payload, zero fill
  always_comb begin
    pIdx = 0;
    for (int i = 0; i < NDW; i++) begin
      nxtDw[i] = '0;
      if (i < 3 || (i == 3 && reqHdr4)) begin
        nxtDw[i] = hdrW[i[1:0]];
      end else begin
        pIdx = i - (reqHdr4 ? 4 : 3);
        if (pIdx >= 0 && pIdx < int'(reqLen))
          nxtDw[i] = payW[pIdx[PIDX_W-1:0]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < MAX_BEATS; k++) pktBeat[k] <= '0;
    end else if (strb.load) begin
      for (int k = 0; k < MAX_BEATS; k++) pktBeat[k] <= nxtBeat[k];
    end
  end

  always_comb begin
    txData = '0;
    if (strb.fire)
      for (int k = 0; k < MAX_BEATS; k++)
        if (strb.beatSel == BEAT_IDX_W'(k)) txData = pktBeat[k];
  end
endmodule

// File: rtl/tlpStreamTx.sv
module tlpStreamTx
  import tlpTxPkg::*;
#(
  parameter int DATA_W    = 128,
  parameter int READY_LAT = 2,
  parameter int MAX_PAY   = 12,
  parameter int HOLD_CYC  = 2,
  localparam int LEN_W    = $clog2(MAX_PAY + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reqValid,
  input  logic                    reqHdr4,
  input  logic [127:0]            reqHdr,
  input  logic [LEN_W-1:0]        reqLen,
  input  logic [MAX_PAY*DW_W-1:0] reqPayload,
  input  logic                    txReady,
  output logic                    reqReady,
  output logic                    txValid,
  output logic                    txSop,
  output logic                    txEop,
  output logic [DATA_W-1:0]       txData,
  output logic                    done
);
  txStrobe_t strb;

  tlpTxCtrl #(
    .READY_LAT(READY_LAT), .HOLD_CYC(HOLD_CYC),
    .MAX_PAY(MAX_PAY), .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqHdr4(reqHdr4),
    .reqLen(reqLen), .txReady(txReady), .reqReady(reqReady),
    .txValid(txValid), .txSop(txSop), .txEop(txEop), .done(done),
    .strb(strb)
  );

  tlpTxData #(.DATA_W(DATA_W), .MAX_PAY(MAX_PAY)) uData (
    .clk(clk), .rst_n(rst_n), .strb(strb), .reqHdr4(reqHdr4),
    .reqHdr(reqHdr), .reqLen(reqLen), .reqPayload(reqPayload),
    .txData(txData)
  );
endmodule

// File: rtl/tlpStreamTxChk.sv
module tlpStreamTxChk #(
  parameter int DATA_W    = 128,
  parameter int READY_LAT = 2,
  parameter int MAX_PAY   = 12,
  localparam int LEN_W    = $clog2(MAX_PAY + 1),
  localparam int DPB      = DATA_W / 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqHdr4,
  input logic [LEN_W-1:0]  reqLen,
  input logic              txReady,
  input logic              reqReady,
  input logic              txValid,
  input logic              txSop,
  input logic              txEop,
  input logic [DATA_W-1:0] txData
);
  int sinceRst;
  int expBeats;
  int seenBeats;

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    txValid |-> $past(txReady, READY_LAT))
    else $error("beat without ready READY_LAT cycles earlier");

  assert_flags_with_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (txSop || txEop) |-> txValid)
    else $error("packet flag without valid");

  assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady)
    else $error("still ready after accepting");

  assert_idle_after_eop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    txEop |=> reqReady)
    else $error("not ready after end beat");

  assert_zero_idle_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !txValid |-> (txData == '0))
    else $error("data nonzero while idle");

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sinceRst  <= 0;
      expBeats  <= 0;
      seenBeats <= 0;
    end else begin
      if (sinceRst < 2) begin
        sinceRst <= sinceRst + 1;
        assert_holdoff_R2: assert (!reqReady && !txValid)
          else $error("activity during reset hold-off");
      end
      if (reqValid && reqReady) begin
        expBeats  <= ((reqHdr4 ? 4 : 3) + int'(reqLen) + DPB - 1) / DPB;
        seenBeats <= 0;
      end else if (txValid) begin
        seenBeats <= seenBeats + 1;
        if (txEop) begin
          assert_beat_count_R5: assert (seenBeats + 1 == expBeats)
            else $error("beat count mismatch");
        end
      end
    end
  end
endmodule

bind tlpStreamTx tlpStreamTxChk #(
  .DATA_W(DATA_W), .READY_LAT(READY_LAT), .MAX_PAY(MAX_PAY)
) uChk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqHdr4(reqHdr4),
  .reqLen(reqLen), .txReady(txReady), .reqReady(reqReady),
  .txValid(txValid), .txSop(txSop), .txEop(txEop), .txData(txData)
);

// File: tb/tb_tlpStreamTx.sv
`timescale 1ns/1ps
module tb_tlpStreamTx;
  localparam int DATA_W    = 128;
  localparam int READY_LAT = 2;
  localparam int MAX_PAY   = 12;
  localparam int LEN_W     = $clog2(MAX_PAY + 1);
  localparam int DPB       = DATA_W / 32;
  localparam int MAX_BEATS = (4 + MAX_PAY + DPB - 1) / DPB;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  reqValid = 1'b0;
  logic                  reqHdr4 = 1'b0;
  logic [127:0]          reqHdr = '0;
  logic [LEN_W-1:0]      reqLen = '0;
  logic [MAX_PAY*32-1:0] reqPayload = '0;
  logic                  txReady = 1'b1;
  logic                  reqReady, txValid, txSop, txEop, done;
  logic [DATA_W-1:0]     txData;

  always #2.5 clk = ~clk;   // 200 MHz

  tlpStreamTx #(.DATA_W(DATA_W), .READY_LAT(READY_LAT), .MAX_PAY(MAX_PAY)) dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqHdr4(reqHdr4),
    .reqHdr(reqHdr), .reqLen(reqLen), .reqPayload(reqPayload),
    .txReady(txReady), .reqReady(reqReady), .txValid(txValid),
    .txSop(txSop), .txEop(txEop), .txData(txData), .done(done)
  );

  int errs = 0, checks = 0, cyc = 0;
  bit pending = 0, acceptNext = 0, holdKnown = 0;
  int beatNo = 0, expBeats = 0, readyMode = 0;
  logic [3:0] drvHist = '1;
  logic [DATA_W-1:0] expBeat [MAX_BEATS];
  int unused;

  task automatic check(bit ok, string req, string what,
                       logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int beatsOf(bit h4, int len);
    return ((h4 ? 4 : 3) + len + DPB - 1) / DPB;
  endfunction

  // packet image from the layout rule (R6)
  function automatic void buildExp(bit h4, logic [127:0] hdr, int len,
                                   logic [MAX_PAY*32-1:0] pay);
    int h = h4 ? 4 : 3;
    for (int b = 0; b < MAX_BEATS; b++)
      for (int j = 0; j < DPB; j++) begin
        int k = b * DPB + j;
        logic [31:0] dw = '0;
        if (k < h) dw = hdr[32*k +: 32];
        else if (k - h < len) dw = pay[32*(k-h) +: 32];
        expBeat[b][32*j +: 32] = dw;
      end
  endfunction

  task automatic monitor();
    bit allowed = drvHist[READY_LAT-1];
    if (holdKnown)
      check(reqReady == !pending, "R3", "reqReady vs busy", reqReady, !pending);
    if (txValid) begin
      check(allowed, "R4", "beat without delayed ready", txValid, allowed);
      check(pending, "R3", "beat without accepted request", txValid, pending);
      if (pending) begin
        check(beatNo < expBeats, "R5", "extra beat", beatNo, expBeats - 1);
        if (beatNo < expBeats)
          check(txData == expBeat[beatNo], "R6", "beat data", txData, expBeat[beatNo]);
        check(txSop == (beatNo == 0), "R7", "sop flag", txSop, beatNo == 0);
        check(txEop == (beatNo == expBeats - 1), "R7", "eop flag", txEop, beatNo == expBeats - 1);
        check(done == txEop, "R8", "done with end beat", done, txEop);
        beatNo++;
        if (txEop) begin
          check(beatNo == expBeats, "R5", "beat count", beatNo, expBeats);
          pending = 0;
        end
      end
    end else begin
      check(txData == '0, "R9", "idle data", txData, '0);
      check(!done, "R8", "done without beat", done, 0);
      check(!txSop && !txEop, "R7", "flags without valid", {txSop, txEop}, 0);
      if (pending)
        check(!allowed, "R4", "allowed slot left unused", txValid, allowed);
    end
  endtask

  task automatic tick();
    bit nr;
    @(negedge clk);
    cyc++;
    if (acceptNext) begin pending = 1; beatNo = 0; acceptNext = 0; end
    monitor();
    case (readyMode)
      0:       nr = 1'b1;
      1:       nr = 1'($urandom % 2);
      default: nr = ($urandom % 4) == 0;
    endcase
    txReady = nr;
    drvHist = {drvHist[2:0], nr};
  endtask

  task automatic sendPkt(bit h4, logic [127:0] hdr, int len,
                         logic [MAX_PAY*32-1:0] pay, bit pokeBusy);
    while (!reqReady) tick();
    buildExp(h4, hdr, len, pay);
    expBeats   = beatsOf(h4, len);
    reqHdr4    = h4;
    reqHdr     = hdr;
    reqLen     = LEN_W'(len);
    reqPayload = pay;
    reqValid   = 1'b1;
    acceptNext = 1;
    tick();
    reqValid = 1'b0;
    if (pokeBusy) begin   // R3: request while busy must be ignored
      reqHdr   = ~hdr;
      reqHdr4  = ~h4;
      reqLen   = '0;
      reqValid = 1'b1;
      tick();
      reqValid = 1'b0;
    end
    while (pending) tick();
  endtask

  function automatic logic [MAX_PAY*32-1:0] randPay();
    logic [MAX_PAY*32-1:0] p;
    for (int m = 0; m < MAX_PAY; m++) p[32*m +: 32] = $urandom;
    return p;
  endfunction

  function automatic logic [127:0] randHdr();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    #(5.0 * 20000);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    unused = $urandom(32'h5eed_1234);
    readyMode = 0;               // ready high during reset
    repeat (4) begin
      tick();
      check(!txValid && !txSop && !txEop && !done && !reqReady && txData == '0,
            "R1", "reset outputs", {txValid, txSop, txEop, done, reqReady}, 0);
    end
    rst_n = 1'b1;
    tick();
    check(!reqReady, "R2", "hold-off first cycle", reqReady, 0);
    tick();
    check(reqReady, "R2", "ready after two edges", reqReady, 1);
    holdKnown = 1;

    // directed corners
    sendPkt(1'b0, randHdr(), 0, randPay(), 1'b1);  // R7 one beat, sop+eop
    sendPkt(1'b0, randHdr(), 1, randPay(), 1'b0);  // exactly 4 dwords, one beat
    sendPkt(1'b1, randHdr(), 1, randPay(), 1'b0);  // R5 two beats, zero fill
    sendPkt(1'b1, randHdr(), MAX_PAY, randPay(), 1'b1);  // full buffer
    readyMode = 2;
    sendPkt(1'b0, randHdr(), 9, randPay(), 1'b0);  // R4 sparse ready, exact fill
    readyMode = 1;
    sendPkt(1'b1, randHdr(), 0, randPay(), 1'b1);  // message style, header only

    for (int n = 0; n < 40; n++) begin
      readyMode = int'($urandom % 3);
      repeat ($urandom % 3) tick();
      sendPkt(1'($urandom % 2), randHdr(), int'($urandom % (MAX_PAY + 1)),
              randPay(), 1'($urandom % 2));
    end
    readyMode = 0;
    repeat (8) tick();   // R3: no stray beats after the last packet

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule